// File: doc/BRIEF.md
# Address Range Attribute Matcher

This block works out the memory attributes of each access from its address. Software programs two address windows and one global control word. Each window holds an 8-bit base, which is compared with address bits 31..24, and an 8-bit don't-care mask. A window also holds an enable, a 2-bit caching-mode field and a write-protect bit. The control word holds a cache-enable bit and a default caching-mode field.

An access is presented with `acc_valid`. One clock later the block reports the following:
- which window supplied the attributes;
- the caching mode that results;
- whether the access may be cached;
- whether the window is write-protected;
- whether the access is a write that violates the protection.

Window 0 has priority over window 1. When neither window matches, the default mode applies. Mode values 00 and 01 are cacheable. Mode values 10 and 11 are cache-inhibited.

The block sits between the address generation of a core and its cache and bus logic. Those downstream units act on the reported attributes. This block does not.

Top module: `mem_attr_matcher`

## Requirements
- R1: After reset, both windows and the control word read as all zero. An access then reports no window hit, mode 00, not cacheable, no protection and no fault.
- R2: The result registers update on the clock edge that samples the access. `res_valid` equals the `acc_valid` of the previous cycle. With `acc_valid` low, `res_fault` stays low.
- R3: A window matches when it is enabled and `(acc_addr[31:24] ^ base) & ~mask` is zero. A mask bit of 1 makes that address bit don't-care.
- R4: When window 0 matches, its mode and write-protect are reported and `res_hit` is 2'b01, even if window 1 also matches.
- R5: When window 0 misses and window 1 matches, window 1's mode and write-protect are reported and `res_hit` is 2'b10.
- R6: When neither window matches, `res_hit` is 2'b00, `res_mode` is the default-mode field of the control word, and `res_wp` is 0.
- R7: A window whose enable bit is 0 never matches, whatever its base and mask.
- R8: `res_cacheable` is 1 only when the control word's cache-enable bit is 1 and bit 1 of the reported mode is 0. Mode values 00 and 01 are cacheable; 10 and 11 are cache-inhibited.
- R9: `res_fault` is 1 exactly when a valid write access gets `res_wp` = 1.
- R10: A write with `cfg_we` = 1 loads the target selected by `cfg_sel`:
  - 0 loads window 0 and 1 loads window 1. A window word holds base in [31:24], mask in [23:16], enable in [15], mode in [6:5] and write-protect in [2].
  - 2 loads the control word, which holds cache-enable in [31] and default mode in [9:8].
  - 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0/1 window, 2 control, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access address |
| res_valid | output | 1 | Result valid, one cycle after the access |
| res_hit | output | 2 | One-hot window that supplied attributes, 0 on miss |
| res_mode | output | 2 | Effective caching-mode field |
| res_cacheable | output | 1 | Access may be cached |
| res_wp | output | 1 | Matched window is write-protected |
| res_fault | output | 1 | Write to a write-protected window |

## Verification
The assertions take for granted that configuration writes and accesses are presented as ordinary single-cycle inputs, with no relation between them. They relate each result to the access and control values of the preceding cycle. This depends on the control word holding steady across that edge, or on a change being seen one edge later. The bench makes sure of this by writing the configuration in cycles with no access. It then sweeps every value of the upper address byte with both read and write. The sweep covers overlapping windows, a disabled all-covering window, a cache-disabled setting and an ignored write target.

// File: rtl/mam_pkg.sv
package mam_pkg;
    localparam int TAG_W   = 8;
    localparam int MODE_W  = 2;
    localparam int DATA_W  = 32;

    // window word layout
    localparam int WIN_BASE_LSB = 24;
    localparam int WIN_MASK_LSB = 16;
    localparam int WIN_EN_BIT   = 15;
    localparam int WIN_MODE_LSB = 5;
    localparam int WIN_WP_BIT   = 2;
    // control word layout
    localparam int CTL_EN_BIT   = 31;
    localparam int CTL_MODE_LSB = 8;

    typedef struct packed {
        logic [TAG_W-1:0]  base;
        logic [TAG_W-1:0]  mask;
        logic              en;
        logic [MODE_W-1:0] mode;
        logic              wp;
    } win_cfg_t;

    typedef struct packed {
        logic              cache_en;
        logic [MODE_W-1:0] dflt_mode;
    } ctl_cfg_t;

    function automatic win_cfg_t unpack_win(input logic [DATA_W-1:0] w);
        win_cfg_t r;
        r.base = w[WIN_BASE_LSB +: TAG_W];
        r.mask = w[WIN_MASK_LSB +: TAG_W];
        r.en   = w[WIN_EN_BIT];
        r.mode = w[WIN_MODE_LSB +: MODE_W];
        r.wp   = w[WIN_WP_BIT];
        return r;
    endfunction

    function automatic ctl_cfg_t unpack_ctl(input logic [DATA_W-1:0] w);
        ctl_cfg_t r;
        r.cache_en  = w[CTL_EN_BIT];
        r.dflt_mode = w[CTL_MODE_LSB +: MODE_W];
        return r;
    endfunction
endpackage

// File: rtl/mam_cfg_regs.sv
module mam_cfg_regs
    import mam_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int SEL_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [SEL_W-1:0]              sel,
    input  logic [DATA_W-1:0]             wdata,
    output win_cfg_t [NUM_WIN-1:0]        win_q,
    output ctl_cfg_t                      ctl_q
);
    localparam logic [SEL_W-1:0] CTL_SEL = SEL_W'(NUM_WIN);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_q[i] <= '0;
            end else if (we && sel == SEL_W'(i)) begin
                win_q[i] <= unpack_win(wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we && sel == CTL_SEL) begin
            ctl_q <= unpack_ctl(wdata);
        end
    end
endmodule

// File: rtl/mam_win_cmp.sv
module mam_win_cmp
    import mam_pkg::*;
(
    input  win_cfg_t         cfg,
    input  logic [TAG_W-1:0] tag,
    output logic             match
);
    logic [TAG_W-1:0] diff;

    always_comb begin
        diff  = (tag ^ cfg.base) & ~cfg.mask;
        match = cfg.en && (diff == '0);
    end
endmodule

// File: rtl/mam_prio_sel.sv
module mam_prio_sel
    import mam_pkg::*;
#(
    parameter int NUM_WIN = 2
) (
    input  logic [NUM_WIN-1:0]     match,
    input  win_cfg_t [NUM_WIN-1:0] win,
    input  ctl_cfg_t               ctl,
    output logic [NUM_WIN-1:0]     hit,
    output logic [MODE_W-1:0]      mode,
    output logic                   wp,
    output logic                   cacheable
);
    always_comb begin
        hit  = '0;
        mode = ctl.dflt_mode;
        wp   = 1'b0;
        // scan from the lowest priority so the lowest index wins
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = '0;
                hit[i]  = 1'b1;
                mode    = win[i].mode;
                wp      = win[i].wp;
            end
        end
        cacheable = ctl.cache_en && !mode[MODE_W-1];
    end
endmodule

// File: rtl/mem_attr_matcher.sv
module mem_attr_matcher
    import mam_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 2,
    parameter int SEL_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ADDR_W-1:0]    acc_addr,
    output logic                 res_valid,
    output logic [NUM_WIN-1:0]   res_hit,
    output logic [MODE_W-1:0]    res_mode,
    output logic                 res_cacheable,
    output logic                 res_wp,
    output logic                 res_fault
);
    localparam int TAG_LSB = ADDR_W - TAG_W;

    win_cfg_t [NUM_WIN-1:0] win_q;
    ctl_cfg_t               ctl_q;
    logic [TAG_W-1:0]       tag;
    logic [NUM_WIN-1:0]     match;
    logic [NUM_WIN-1:0]     hit_d;
    logic [MODE_W-1:0]      mode_d;
    logic                   wp_d;
    logic                   cach_d;
    logic                   cache_en_w;
    logic [MODE_W-1:0]      dflt_mode_w;

    assign tag         = acc_addr[TAG_LSB +: TAG_W];
    assign cache_en_w  = ctl_q.cache_en;
    assign dflt_mode_w = ctl_q.dflt_mode;

    mam_cfg_regs #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .win_q (win_q),
        .ctl_q (ctl_q)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        mam_win_cmp u_cmp (
            .cfg   (win_q[i]),
            .tag   (tag),
            .match (match[i])
        );
    end

    mam_prio_sel #(.NUM_WIN(NUM_WIN)) u_sel (
        .match     (match),
        .win       (win_q),
        .ctl       (ctl_q),
        .hit       (hit_d),
        .mode      (mode_d),
        .wp        (wp_d),
        .cacheable (cach_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_hit       <= '0;
            res_mode      <= '0;
            res_cacheable <= 1'b0;
            res_wp        <= 1'b0;
            res_fault     <= 1'b0;
        end else begin
            res_valid     <= acc_valid;
            res_hit       <= acc_valid ? hit_d : '0;
            res_mode      <= acc_valid ? mode_d : '0;
            res_cacheable <= acc_valid && cach_d;
            res_wp        <= acc_valid && wp_d;
            res_fault     <= acc_valid && acc_write && wp_d;
        end
    end
endmodule

// File: rtl/mam_checker.sv
module mam_checker #(
    parameter int NUM_WIN = 2,
    parameter int MODE_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic               res_valid,
    input logic [NUM_WIN-1:0] res_hit,
    input logic [MODE_W-1:0]  res_mode,
    input logic               res_cacheable,
    input logic               res_wp,
    input logic               res_fault,
    input logic               cache_en,
    input logic [MODE_W-1:0]  dflt_mode
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> res_valid == $past(acc_valid)); // R2

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_hit)); // R4

    AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_valid && res_hit == '0) |-> (res_mode == $past(dflt_mode) && !res_wp)); // R6

    AST_OFF_NOT_CACHED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cache_en)) |-> !res_cacheable); // R8

    AST_FAULT_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_fault) |-> (res_wp && $past(acc_valid) && $past(acc_write))); // R9

    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_fault); // R2
endmodule

bind mem_attr_matcher mam_checker #(.NUM_WIN(NUM_WIN), .MODE_W(mam_pkg::MODE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .res_valid     (res_valid),
    .res_hit       (res_hit),
    .res_mode      (res_mode),
    .res_cacheable (res_cacheable),
    .res_wp        (res_wp),
    .res_fault     (res_fault),
    .cache_en      (cache_en_w),
    .dflt_mode     (dflt_mode_w)
);

// File: tb/mem_attr_matcher_tb.sv
module mem_attr_matcher_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        res_valid;
    logic [1:0]  res_hit;
    logic [1:0]  res_mode;
    logic        res_cacheable;
    logic        res_wp;
    logic        res_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_w0 = '0, m_w1 = '0, m_ctl = '0;

    always #2.5 clk = ~clk;

    mem_attr_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .res_valid(res_valid), .res_hit(res_hit),
        .res_mode(res_mode), .res_cacheable(res_cacheable), .res_wp(res_wp),
        .res_fault(res_fault)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic win_match(input logic [31:0] w, input logic [7:0] tag);
        return w[15] && (((tag ^ w[31:24]) & ~w[23:16]) == 8'h00);
    endfunction

    function automatic logic [31:0] mk_win(input logic [7:0] b, input logic [7:0] m,
                                           input logic en, input logic [1:0] md, input logic wp);
        logic [31:0] w = '0;
        w[31:24] = b; w[23:16] = m; w[15] = en; w[6:5] = md; w[2] = wp;
        return w;
    endfunction

    task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) m_w0 = d;          // R10
        else if (sel == 2'd1) m_w1 = d;
        else if (sel == 2'd2) m_ctl = d;
    endtask

    task automatic access(input logic [7:0] tag, input logic wr, input logic [23:0] low);
        logic m0, m1, e_wp;
        logic [1:0] e_hit, e_mode;
        acc_valid = 1'b1; acc_write = wr; acc_addr = {tag, low};
        @(negedge clk);
        acc_valid = 1'b0;
        m0 = win_match(m_w0, tag);
        m1 = win_match(m_w1, tag);
        if (m0) begin e_hit = 2'b01; e_mode = m_w0[6:5]; e_wp = m_w0[2]; end
        else if (m1) begin e_hit = 2'b10; e_mode = m_w1[6:5]; e_wp = m_w1[2]; end
        else begin e_hit = 2'b00; e_mode = m_ctl[9:8]; e_wp = 1'b0; end
        chk("R2 valid", int'(res_valid), 1);
        if (m0 && m1) chk("R4 overlap hit", int'(res_hit), int'(e_hit));
        else if (m1) chk("R5 second hit", int'(res_hit), int'(e_hit));
        else chk("R3/R7 hit", int'(res_hit), int'(e_hit));
        if (e_hit == 2'b00) chk("R6 default mode", int'(res_mode), int'(e_mode));
        else chk("R3 window mode", int'(res_mode), int'(e_mode));
        chk("R8 cacheable", int'(res_cacheable), int'(m_ctl[31] && !e_mode[1]));
        chk("R9 wp", int'(res_wp), int'(e_wp));
        chk("R9 fault", int'(res_fault), int'(wr && e_wp));
    endtask

    task automatic sweep();
        for (int t = 0; t < 256; t++) begin
            access(8'(t), 1'b0, 24'h00_1234);
            access(8'(t), 1'b1, 24'hFF_FFF0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", int'(res_valid), 0);
        chk("R1 fault", int'(res_fault), 0);
        access(8'hA5, 1'b1, 24'h0);
        chk("R1 hit", int'(res_hit), 0);
        chk("R1 mode", int'(res_mode), 0);
        chk("R1 cacheable", int'(res_cacheable), 0);
        chk("R1 wp", int'(res_wp), 0);
        // R2: idle cycle with write asserted
        acc_write = 1'b1;
        @(negedge clk);
        chk("R2 idle valid", int'(res_valid), 0);
        chk("R2 idle fault", int'(res_fault), 0);
        acc_write = 1'b0;

        // overlapping windows, window 0 inside window 1
        wr_cfg(2'd0, mk_win(8'h40, 8'h0F, 1'b1, 2'b00, 1'b0));
        wr_cfg(2'd1, mk_win(8'h40, 8'h3F, 1'b1, 2'b10, 1'b1));
        wr_cfg(2'd2, 32'h8000_0100);
        sweep();

        // R7: disabled all-covering window 0
        wr_cfg(2'd0, mk_win(8'h00, 8'hFF, 1'b0, 2'b11, 1'b1));
        wr_cfg(2'd1, mk_win(8'h80, 8'h7F, 1'b1, 2'b11, 1'b1));
        wr_cfg(2'd2, 32'h8000_0200);
        sweep();

        // R8: cache disabled, cacheable modes everywhere
        wr_cfg(2'd0, mk_win(8'hFF, 8'h00, 1'b1, 2'b01, 1'b1));
        wr_cfg(2'd1, mk_win(8'h00, 8'hFF, 1'b1, 2'b00, 1'b0));
        wr_cfg(2'd2, 32'h0000_0100);
        sweep();

        // R10: target 3 ignored; odd mask pattern
        wr_cfg(2'd0, mk_win(8'h5A, 8'h81, 1'b1, 2'b01, 1'b1));
        wr_cfg(2'd1, 32'h0000_0000);
        wr_cfg(2'd2, 32'h8000_0300);
        wr_cfg(2'd3, 32'hFFFF_FFFF);
        sweep();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule